// File: doc/BRIEF.md
# Predicated Vector Absolute Max/Min Unit

This block executes one of two 128-bit SIMD operations that fold a signed source vector into an unsigned accumulator vector. The block splits each operand into lanes of 8, 16 or 32 bits. It converts every source lane to its magnitude and compares that magnitude, as an unsigned number, with the matching accumulator lane. The larger value is kept in the max form and the smaller value in the min form. A per-byte write mask then decides which result bytes replace the accumulator bytes. Bytes whose mask bit is clear keep their old accumulator value.

The caller presents a 32-bit instruction word together with both operand vectors and the mask, and pulses `in_valid` for one cycle. A built-in decoder checks the fixed encoding bits and pulls out three fields: the lane width, the max/min choice and the two register indices. One cycle later the registered result appears, with `out_valid` high for exactly that cycle. A word that fails to decode, or that names the reserved width, raises `out_undef` and returns the accumulator unchanged.

A two-state controller produces the output strobe. `ST_IDLE` moves to `ST_SHOW` when `in_valid` is high. `ST_SHOW` stays in `ST_SHOW` on a back-to-back strobe and otherwise returns to `ST_IDLE`. `out_valid` is high only in `ST_SHOW`.

Top module: `vamm_unit`

## Requirements
- R1: Width code 0 (instruction bits [19:18]) splits the vectors into sixteen 8-bit lanes. Each lane result is the magnitude of the signed source lane or the unsigned accumulator lane, whichever the mode selects.
- R2: Width code 1 gives eight 16-bit lanes, with the same per-lane rule as R1.
- R3: Width code 2 gives four 32-bit lanes, with the same per-lane rule as R1.
- R4: Instruction bit 12 = 0 keeps the unsigned larger value. Bit 12 = 1 keeps the unsigned smaller value.
- R5: The magnitude of the most negative lane value (0x80, 0x8000, 0x80000000) is that same pattern read as unsigned. It is not saturated.
- R6: Mask bit b governs result byte b (bits 8b+7..8b). When the bit is set the byte takes the computed value; when it is clear the byte takes the accumulator byte. A wide lane can therefore be written only in part.
- R7: Width code 3 raises `out_undef` and returns the accumulator unchanged.
- R8: A word that breaks the fixed pattern raises `out_undef` and returns the accumulator unchanged. The fixed pattern is bits [31:23]=111011100, [21:20]=11, [17:16]=11, [11:8]=1110, bit7=1, bit6=0, bit4=0, bit0=1.
- R9: `out_valid` is low after reset. It is high in the cycle after each cycle in which `in_valid` is high, and low in every other cycle. The outputs are registered with the same timing.
- R10: `out_qd` equals {bit 22, bits [15:13]} and `out_qm` equals {bit 5, bits [3:1]} of the accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Signed source vector |
| acc_vec | input | 128 | Unsigned accumulator vector |
| pred_mask | input | 16 | Per-byte write mask |
| out_valid | output | 1 | Result strobe |
| out_vec | output | 128 | Merged result |
| out_undef | output | 1 | Undefined-encoding flag |
| out_qd | output | 4 | Accumulator register index |
| out_qm | output | 4 | Source register index |

## Verification
The hardest case to reach from the ports is a wide lane that is only partly written. Here the kept bytes and the replaced bytes of one 16-bit or 32-bit element come from different operands. The stimulus reaches it with alternating and half-vector masks on 16-bit and 32-bit operations. Their sources carry negative values whose magnitudes differ from the accumulator in every byte, so a merge done per lane instead of per byte shows up as a wrong byte. The minimum-value patterns are driven at all three widths against accumulators on either side of them. A saturating magnitude circuit would then pick the other operand.

// File: rtl/vamm_pkg.sv
package vamm_pkg;
    typedef enum logic [1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_W   = 2'd2,
        SZ_RSV = 2'd3
    } esize_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } vstate_t;

    typedef struct packed {
        logic       hit;
        esize_t     size;
        logic       is_min;
        logic [3:0] qd;
        logic [3:0] qm;
    } dec_t;
endpackage

// File: rtl/vamm_decode.sv
module vamm_decode
    import vamm_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    logic fixed_ok;

    always_comb begin
        fixed_ok = (insn[31:23] == 9'b1110_1110_0) &&
                   (insn[21:20] == 2'b11) &&
                   (insn[17:16] == 2'b11) &&
                   (insn[11:8]  == 4'b1110) &&
                   insn[7] && !insn[6] && !insn[4] && insn[0];
        dec.hit    = fixed_ok;
        dec.size   = esize_t'(insn[19:18]);
        dec.is_min = insn[12];
        dec.qd     = {insn[22], insn[15:13]};
        dec.qm     = {insn[5], insn[3:1]};
    end
endmodule

// File: rtl/vamm_lane.sv
module vamm_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] s_val,
    input  logic [W-1:0] d_val,
    input  logic         is_min,
    output logic [W-1:0] r_val
);
    logic [W-1:0] mag;
    logic         mag_lt;

    always_comb begin
        // two's complement negate wraps the minimum value onto itself
        mag    = s_val[W-1] ? (~s_val + W'(1)) : s_val;
        mag_lt = mag < d_val;
        if (is_min) r_val = mag_lt ? mag : d_val;
        else        r_val = mag_lt ? d_val : mag;
    end
endmodule

// File: rtl/vamm_unit.sv
module vamm_unit
    import vamm_pkg::*;
#(
    parameter int VEC_W = 128,
    localparam int NBYTE = VEC_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      insn,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] acc_vec,
    input  logic [NBYTE-1:0] pred_mask,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_undef,
    output logic [3:0]       out_qd,
    output logic [3:0]       out_qm
);
    localparam int NSIZE = 3;

    dec_t             dec;
    vstate_t          state, state_nx;
    logic [VEC_W-1:0] res_sz [NSIZE];
    logic [VEC_W-1:0] picked;
    logic [VEC_W-1:0] merged;
    logic             undef_now;

    vamm_decode u_dec (.insn(insn), .dec(dec));

    for (genvar sz = 0; sz < NSIZE; sz++) begin : g_size
        localparam int LW = 8 << sz;
        localparam int NL = VEC_W / LW;
        for (genvar ln = 0; ln < NL; ln++) begin : g_lane
            vamm_lane #(.W(LW)) u_lane (
                .s_val (src_vec[ln*LW +: LW]),
                .d_val (acc_vec[ln*LW +: LW]),
                .is_min(dec.is_min),
                .r_val (res_sz[sz][ln*LW +: LW])
            );
        end
    end

    always_comb begin
        unique case (dec.size)
            SZ_B:    picked = res_sz[0];
            SZ_H:    picked = res_sz[1];
            SZ_W:    picked = res_sz[2];
            default: picked = acc_vec;
        endcase
    end

    assign undef_now = !dec.hit || (dec.size == SZ_RSV);

    for (genvar b = 0; b < NBYTE; b++) begin : g_merge
        assign merged[b*8 +: 8] = (pred_mask[b] && !undef_now) ?
                                  picked[b*8 +: 8] : acc_vec[b*8 +: 8];
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nx = in_valid ? ST_SHOW : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec   <= '0;
            out_undef <= 1'b0;
            out_qd    <= '0;
            out_qm    <= '0;
        end else if (in_valid) begin
            out_vec   <= merged;
            out_undef <= undef_now;
            out_qd    <= dec.qd;
            out_qm    <= dec.qm;
        end
    end

    assign out_valid = (state == ST_SHOW);
endmodule

// File: rtl/vamm_chk.sv
module vamm_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [31:0]  insn,
    input logic [127:0] src_vec,
    input logic [127:0] acc_vec,
    input logic [15:0]  pred_mask,
    input logic         out_valid,
    input logic [127:0] out_vec,
    input logic         out_undef,
    input logic [3:0]   out_qd,
    input logic [3:0]   out_qm
);
    // R9
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    reserved_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[19:18] == 2'b11) |=> (out_undef && out_vec == $past(acc_vec)));

    // R6
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_mask == 16'h0) |=> (out_vec == $past(acc_vec)));

    // R8
    undef_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_undef) |-> (out_vec == $past(acc_vec)));

    // R10
    index_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_qd == {$past(insn[22]), $past(insn[15:13])} &&
                      out_qm == {$past(insn[5]), $past(insn[3:1])}));
endmodule

bind vamm_unit vamm_chk u_vamm_chk (.*);

// File: tb/tb_vamm_unit.sv
module tb_vamm_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] src_vec = '0;
    logic [127:0] acc_vec = '0;
    logic [15:0]  pred_mask = '0;
    logic         out_valid;
    logic [127:0] out_vec;
    logic         out_undef;
    logic [3:0]   out_qd;
    logic [3:0]   out_qm;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [127:0] vec;
        logic         undef;
        logic [3:0]   qd;
        logic [3:0]   qm;
        string        tag;
    } exp_t;

    exp_t sb[$];

    vamm_unit dut (.*);

    always #10 clk = ~clk;

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic mn,
                                       input logic [3:0] qd, input logic [3:0] qm);
        return {8'hEE, 1'b0, qd[3], 2'b11, sz, 2'b11, qd[2:0], mn,
                4'b1110, 1'b1, 1'b0, qm[3], 1'b0, qm[2:0], 1'b1};
    endfunction

    function automatic exp_t model(input logic [31:0] w, input logic [127:0] s,
                                   input logic [127:0] d, input logic [15:0] m);
        exp_t e;
        logic ok;
        int bw;
        ok = (w[31:23] == 9'h1DC) && (w[21:20] == 2'b11) && (w[17:16] == 2'b11) &&
             (w[11:8] == 4'hE) && w[7] && !w[6] && !w[4] && w[0] && (w[19:18] != 2'b11);
        e.qd = {w[22], w[15:13]};
        e.qm = {w[5], w[3:1]};
        e.undef = !ok;
        e.vec = d;
        if (ok) begin
            bw = 1 << w[19:18];
            for (int ln = 0; ln < 16 / bw; ln++) begin
                longint unsigned sv, dv, mg, rv;
                sv = 0; dv = 0;
                for (int k = 0; k < bw; k++) begin
                    sv = sv | (longint'(s[(ln*bw+k)*8 +: 8]) << (8*k));
                    dv = dv | (longint'(d[(ln*bw+k)*8 +: 8]) << (8*k));
                end
                if (sv[bw*8-1]) mg = (64'd1 << (bw*8)) - sv;
                else            mg = sv;
                if (w[12]) rv = (mg < dv) ? mg : dv;
                else       rv = (mg > dv) ? mg : dv;
                for (int k = 0; k < bw; k++)
                    if (m[ln*bw+k]) e.vec[(ln*bw+k)*8 +: 8] = rv[8*k +: 8];
            end
        end
        return e;
    endfunction

    task automatic drive(input logic [31:0] w, input logic [127:0] s,
                         input logic [127:0] d, input logic [15:0] m, input string tag);
        exp_t e;
        @(negedge clk);
        insn = w; src_vec = s; acc_vec = d; pred_mask = m; in_valid = 1'b1;
        e = model(w, s, d, m);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_valid) begin
                exp_t e;
                n_checks++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: out_valid=1 actual, expected 0 (nothing pending)");
                end else begin
                    e = sb.pop_front();
                    if (out_vec !== e.vec || out_undef !== e.undef ||
                        out_qd !== e.qd || out_qm !== e.qm) begin
                        n_fail++;
                        $display("FAIL %s: actual vec=%h undef=%b qd=%h qm=%h expected vec=%h undef=%b qd=%h qm=%h",
                                 e.tag, out_vec, out_undef, out_qd, out_qm,
                                 e.vec, e.undef, e.qd, e.qm);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [127:0] sA, dA, sMin8, sMin16, sMin32;
        sA = 128'hF3_7F_01_FF_80_10_C0_22_E5_05_9A_40_00_81_6C_D0;
        dA = 128'h10_20_30_40_50_60_70_80_90_A0_B0_C0_D0_E0_F0_0F;
        sMin8  = {16{8'h80}};
        sMin16 = {8{16'h8000}};
        sMin32 = {4{32'h8000_0000}};
        repeat (3) @(negedge clk);
        #1;
        n_checks++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            n_fail++;
            $display("FAIL R9 reset: actual valid=%b vec=%h expected 0/0", out_valid, out_vec);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(mk(2'd0, 1'b0, 4'h3, 4'hA), sA, dA, 16'hFFFF, "R1 byte max");
        drive(mk(2'd1, 1'b0, 4'hC, 4'h5), sA, dA, 16'hFFFF, "R2 half max");
        drive(mk(2'd2, 1'b0, 4'h7, 4'h8), sA, dA, 16'hFFFF, "R3 word max");
        drive(mk(2'd0, 1'b1, 4'h1, 4'hF), sA, dA, 16'hFFFF, "R4 byte min");
        drive(mk(2'd2, 1'b1, 4'hE, 4'h2), sA, ~dA, 16'hFFFF, "R4 word min");
        drive(mk(2'd1, 1'b1, 4'h9, 4'h6), ~sA, dA, 16'hFFFF, "R2 R4 half min");
        idle();
        drive(mk(2'd0, 1'b0, 4'h0, 4'h0), sMin8, {16{8'h7F}}, 16'hFFFF, "R5 byte max minval");
        drive(mk(2'd1, 1'b1, 4'h4, 4'h4), sMin16, {8{16'h8001}}, 16'hFFFF, "R5 half min minval");
        drive(mk(2'd2, 1'b1, 4'hB, 4'hD), sMin32, {4{32'hFFFF_FFFF}}, 16'hFFFF, "R5 word min minval");
        drive(mk(2'd1, 1'b0, 4'h2, 4'h3), sA, dA, 16'h5555, "R6 half alternating mask");
        drive(mk(2'd2, 1'b0, 4'h6, 4'h1), {4{32'hFEDC_BA98}}, '0, 16'h00F6, "R6 word partial mask");
        drive(mk(2'd0, 1'b0, 4'h5, 4'h7), sA, dA, 16'h0000, "R6 empty mask");
        idle();
        idle();
        drive(mk(2'd3, 1'b0, 4'h8, 4'h9), sA, dA, 16'hFFFF, "R7 reserved width");
        drive(mk(2'd0, 1'b0, 4'h8, 4'h9) | 32'h0000_0040, sA, dA, 16'hFFFF, "R8 bit6 set");
        drive(mk(2'd1, 1'b0, 4'h8, 4'h9) & ~32'h0001_0000, sA, dA, 16'hFFFF, "R8 bit16 clear");
        drive(mk(2'd2, 1'b1, 4'hF, 4'hF), sA, dA, 16'hFFFF, "R10 max indices");
        idle();
        idle();
        // R9: no strobe pending, out_valid must stay low
        #1;
        n_checks++;
        if (out_valid !== 1'b0 || sb.size() != 0) begin
            n_fail++;
            $display("FAIL R9 idle: actual valid=%b pending=%0d expected 0/0", out_valid, sb.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule